// File: doc/BRIEF.md
# Masked Address Breakpoint Event Detector

This block watches two data-access address buses of a processor core for breakpoint conditions. Each bus has its own comparator. A comparator masks the sampled address with a programmable mask and tests the result against a programmed reference. It can report either equality or inequality.

A combine setting merges the two comparator results into one qualified hit. The hit is honoured only while the detector is armed. On a qualified hit the block pulses exactly one of four action outputs for a single cycle: debug exception, debug request to the core, trace start or trace stop.

On the first hit after a clear, the block latches a status word and the program counter of the triggering access. Both stay fixed until software clears them, and a host interrupt line stays high for as long as they hold a hit. Configuration goes through a simple word-indexed register write port, which stands in for a debug controller driven over JTAG. A combinational read port returns any register. Two external control lines can arm or disarm the detector without a register write.

Top module: `addr_bkpt_detector`

## Requirements
- R1: After reset every register reads as zero, the detector is disarmed, and all action outputs and `host_irq` are low.
- R2: Comparator A reports equal when `a_valid` is high and (`a_addr` AND mask A) equals reference A. Comparator B does the same with `b_valid`, `b_addr`, mask B and reference B. A comparator whose valid input is low never reports a match.
- R3: CTRL bit 2 (A) and CTRL bit 3 (B) each invert their own comparator's test to not-equal. A comparator set this way still requires its valid input.
- R4: CTRL bits [1:0] pick how the two results combine: 0 = A or B, 1 = A and B in the same cycle, 2 = A only, 3 = B only.
- R5: CTRL bits [5:4] pick the action: 0 = `evt_dbg_exc`, 1 = `evt_dbg_req`, 2 = `evt_trace_on`, 3 = `evt_trace_off`. Every qualified hit at clock edge N raises only the chosen output, high for exactly the cycle after edge N.
- R6: While disarmed, matching accesses raise no action and leave STATUS and CAPPC unchanged.
- R7: Arming takes effect from the next edge. The arm state follows a fixed priority: `ext_disarm` clears it first; otherwise `ext_arm` sets it; otherwise a write to ENABLE (index 5) loads wdata bit 0.
- R8: The first qualified hit while STATUS bit 0 is clear captures two values at the same edge. CAPPC (index 7) takes `pc_in`. STATUS (index 6) takes bit0 = 1, bit1 = A result, bit2 = B result and bits[4:3] = action code. Later hits leave both registers unchanged.
- R9: Any write to STATUS clears STATUS and CAPPC. If a qualified hit occurs at the same edge, the new hit is captured instead.
- R10: `host_irq` equals STATUS bit 0.
- R11: Register indices 0 through 3 read back reference A, mask A, reference B and mask B. CTRL (index 4) reads back bits [5:0] and ENABLE (index 5) reads back bit 0. Writes to index 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write index |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_raddr | input | 3 | Register read index |
| cfg_rdata | output | ADDR_W | Register read data, combinational |
| ext_arm | input | 1 | External arm request |
| ext_disarm | input | 1 | External disarm request |
| a_valid | input | 1 | Bus A access valid |
| a_addr | input | ADDR_W | Bus A address |
| b_valid | input | 1 | Bus B access valid |
| b_addr | input | ADDR_W | Bus B address |
| pc_in | input | PC_W | Program counter of the current access |
| evt_dbg_exc | output | 1 | Debug exception pulse |
| evt_dbg_req | output | 1 | Debug request pulse |
| evt_trace_on | output | 1 | Trace start pulse |
| evt_trace_off | output | 1 | Trace stop pulse |
| host_irq | output | 1 | Host interrupt, high while a hit is held |

## Verification
Several properties are checked on every cycle:
- At most one action output is ever high.
- No action follows a cycle that was disarmed or had no valid access.
- An external disarm always leaves the detector disarmed.
- A held hit keeps the captured PC stable until a clear.
- Any action pulse coincides with a raised interrupt.

The per-bus mask arithmetic, the not-equal inversions, each combine code, the first-hit-wins capture, the race between a clear and a hit, and the arm priority only show in the bench scenarios. There, a behavioural model is compared against every output on every clock.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
   localparam int NUM_CMP   = 2;
   localparam int NUM_ACT   = 4;
   localparam int REG_IDX_W = 3;
   localparam int STAT_W    = 5;

   typedef enum logic [1:0] {
      CMB_EITHER = 2'd0,
      CMB_BOTH   = 2'd1,
      CMB_ONLY_A = 2'd2,
      CMB_ONLY_B = 2'd3
   } combine_e;

   typedef enum logic [1:0] {
      ACT_DBG_EXC   = 2'd0,
      ACT_DBG_REQ   = 2'd1,
      ACT_TRACE_ON  = 2'd2,
      ACT_TRACE_OFF = 2'd3
   } action_e;

   localparam logic [REG_IDX_W-1:0] IDX_REF_A  = 3'd0;
   localparam logic [REG_IDX_W-1:0] IDX_MASK_A = 3'd1;
   localparam logic [REG_IDX_W-1:0] IDX_REF_B  = 3'd2;
   localparam logic [REG_IDX_W-1:0] IDX_MASK_B = 3'd3;
   localparam logic [REG_IDX_W-1:0] IDX_CTRL   = 3'd4;
   localparam logic [REG_IDX_W-1:0] IDX_ENABLE = 3'd5;
   localparam logic [REG_IDX_W-1:0] IDX_STATUS = 3'd6;
   localparam logic [REG_IDX_W-1:0] IDX_CAPPC  = 3'd7;

   typedef struct packed {
      action_e  act;
      logic     hit_b;
      logic     hit_a;
      logic     valid;
   } status_t;

   typedef struct packed {
      action_e  act;
      logic     neq_b;
      logic     neq_a;
      combine_e comb;
   } ctrl_t;
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
   parameter int ADDR_W = 32
) (
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [ADDR_W-1:0] ref_val,
   input  logic [ADDR_W-1:0] mask_val,
   input  logic              invert,
   output logic              match
);
   logic [ADDR_W-1:0] masked;
   logic              equal;

   always_comb begin
      masked = acc_addr & mask_val;
      equal  = (masked == ref_val);
      match  = acc_valid & (equal ^ invert);
   end
endmodule

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
   import bkpt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PC_W   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [REG_IDX_W-1:0] cfg_waddr,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   input  logic [REG_IDX_W-1:0] cfg_raddr,
   output logic [ADDR_W-1:0]    cfg_rdata,
   input  logic                 ext_arm,
   input  logic                 ext_disarm,
   input  status_t              status_q,
   input  logic [PC_W-1:0]      cap_pc_q,
   output logic [ADDR_W-1:0]    ref_q  [NUM_CMP],
   output logic [ADDR_W-1:0]    mask_q [NUM_CMP],
   output ctrl_t                ctrl_q,
   output logic                 en_q,
   output logic                 status_clr
);
   localparam int CTRL_W = $bits(ctrl_t);

   logic en_d;

   // reference/mask pairs sit at consecutive indices: ref at 2k, mask at 2k+1
   for (genvar k = 0; k < NUM_CMP; k++) begin : g_pair
      localparam logic [REG_IDX_W-1:0] IDX_R = REG_IDX_W'(2*k);
      localparam logic [REG_IDX_W-1:0] IDX_M = REG_IDX_W'(2*k+1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ref_q[k]  <= '0;
            mask_q[k] <= '0;
         end else if (cfg_we) begin
            if (cfg_waddr == IDX_R) ref_q[k]  <= cfg_wdata;
            if (cfg_waddr == IDX_M) mask_q[k] <= cfg_wdata;
         end
      end
   end

   always_comb begin
      en_d = en_q;
      if (ext_disarm)                              en_d = 1'b0;
      else if (ext_arm)                            en_d = 1'b1;
      else if (cfg_we && cfg_waddr == IDX_ENABLE)  en_d = cfg_wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= 1'b0;
      end else begin
         en_q <= en_d;
         if (cfg_we && cfg_waddr == IDX_CTRL) ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end
   end

   assign status_clr = cfg_we && (cfg_waddr == IDX_STATUS);

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_raddr)
         IDX_REF_A:  cfg_rdata = ref_q[0];
         IDX_MASK_A: cfg_rdata = mask_q[0];
         IDX_REF_B:  cfg_rdata = ref_q[1];
         IDX_MASK_B: cfg_rdata = mask_q[1];
         IDX_CTRL:   cfg_rdata[CTRL_W-1:0] = ctrl_q;
         IDX_ENABLE: cfg_rdata[0] = en_q;
         IDX_STATUS: cfg_rdata[STAT_W-1:0] = status_q;
         IDX_CAPPC:  cfg_rdata[PC_W-1:0] = cap_pc_q;
         default:    cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/bkpt_event_ctl.sv
module bkpt_event_ctl
   import bkpt_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CMP-1:0] cmp_hit,
   input  ctrl_t              ctrl_q,
   input  logic               en_q,
   input  logic               status_clr,
   input  logic [PC_W-1:0]    pc_in,
   output status_t            status_q,
   output logic [PC_W-1:0]    cap_pc_q,
   output logic [NUM_ACT-1:0] evt_q
);
   logic combined;
   logic qual_hit;
   logic capture;

   always_comb begin
      unique case (ctrl_q.comb)
         CMB_EITHER: combined = cmp_hit[0] | cmp_hit[1];
         CMB_BOTH:   combined = cmp_hit[0] & cmp_hit[1];
         CMB_ONLY_A: combined = cmp_hit[0];
         CMB_ONLY_B: combined = cmp_hit[1];
         default:    combined = 1'b0;
      endcase
      qual_hit = en_q & combined;
      capture  = qual_hit & (~status_q.valid | status_clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         cap_pc_q <= '0;
      end else if (capture) begin
         status_q.valid <= 1'b1;
         status_q.hit_a <= cmp_hit[0];
         status_q.hit_b <= cmp_hit[1];
         status_q.act   <= ctrl_q.act;
         cap_pc_q       <= pc_in;
      end else if (status_clr) begin
         status_q <= '0;
         cap_pc_q <= '0;
      end
   end

   for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) evt_q[i] <= 1'b0;
         else        evt_q[i] <= qual_hit && (ctrl_q.act == action_e'(i));
      end
   end
endmodule

// File: rtl/addr_bkpt_detector.sv
module addr_bkpt_detector
   import bkpt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PC_W   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [REG_IDX_W-1:0] cfg_waddr,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   input  logic [REG_IDX_W-1:0] cfg_raddr,
   output logic [ADDR_W-1:0]    cfg_rdata,
   input  logic                 ext_arm,
   input  logic                 ext_disarm,
   input  logic                 a_valid,
   input  logic [ADDR_W-1:0]    a_addr,
   input  logic                 b_valid,
   input  logic [ADDR_W-1:0]    b_addr,
   input  logic [PC_W-1:0]      pc_in,
   output logic                 evt_dbg_exc,
   output logic                 evt_dbg_req,
   output logic                 evt_trace_on,
   output logic                 evt_trace_off,
   output logic                 host_irq
);
   localparam int MIN_W = $bits(ctrl_t) > STAT_W ? $bits(ctrl_t) : STAT_W;

   if (ADDR_W < MIN_W) begin : g_bad_addr_w
      $error("ADDR_W must hold the control and status words");
   end
   if (PC_W > ADDR_W || PC_W < 1) begin : g_bad_pc_w
      $error("PC_W must be between 1 and ADDR_W");
   end

   logic [ADDR_W-1:0]  ref_q  [NUM_CMP];
   logic [ADDR_W-1:0]  mask_q [NUM_CMP];
   logic [ADDR_W-1:0]  bus_addr [NUM_CMP];
   logic [NUM_CMP-1:0] bus_valid;
   logic [NUM_CMP-1:0] cmp_hit;
   logic [NUM_CMP-1:0] neq;
   ctrl_t              ctrl_q;
   logic               en_q;
   logic               status_clr;
   status_t            status_q;
   logic [PC_W-1:0]    cap_pc_q;
   logic [NUM_ACT-1:0] evt_q;

   assign bus_addr[0] = a_addr;
   assign bus_addr[1] = b_addr;
   assign bus_valid   = {b_valid, a_valid};
   assign neq         = {ctrl_q.neq_b, ctrl_q.neq_a};

   bkpt_cfg_regs #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .ext_arm(ext_arm), .ext_disarm(ext_disarm),
      .status_q(status_q), .cap_pc_q(cap_pc_q),
      .ref_q(ref_q), .mask_q(mask_q), .ctrl_q(ctrl_q),
      .en_q(en_q), .status_clr(status_clr)
   );

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
      bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .acc_valid(bus_valid[k]), .acc_addr(bus_addr[k]),
         .ref_val(ref_q[k]), .mask_val(mask_q[k]),
         .invert(neq[k]), .match(cmp_hit[k])
      );
   end

   bkpt_event_ctl #(.PC_W(PC_W)) u_evt (
      .clk(clk), .rst_n(rst_n),
      .cmp_hit(cmp_hit), .ctrl_q(ctrl_q), .en_q(en_q),
      .status_clr(status_clr), .pc_in(pc_in),
      .status_q(status_q), .cap_pc_q(cap_pc_q), .evt_q(evt_q)
   );

   assign evt_dbg_exc   = evt_q[0];
   assign evt_dbg_req   = evt_q[1];
   assign evt_trace_on  = evt_q[2];
   assign evt_trace_off = evt_q[3];
   assign host_irq      = status_q.valid;
endmodule

// File: rtl/addr_bkpt_detector_chk.sv
module addr_bkpt_detector_chk #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [3:0]      evts,
   input logic            en_q,
   input logic            a_valid,
   input logic            b_valid,
   input logic            ext_disarm,
   input logic            host_irq,
   input logic            clr,
   input logic [PC_W-1:0] cap_pc
);
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evts)); // R5
   AST_QUIET_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (evts == 4'b0)); // R6
   AST_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_valid && !b_valid) |=> (evts == 4'b0)); // R2
   AST_DISARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ext_disarm |=> !en_q); // R7
   AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_irq && !clr) |=> $stable(cap_pc)); // R8
   AST_EVT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (evts != 4'b0) |-> host_irq); // R10
endmodule

bind addr_bkpt_detector addr_bkpt_detector_chk #(.PC_W(PC_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .evts({evt_trace_off, evt_trace_on, evt_dbg_req, evt_dbg_exc}),
   .en_q(en_q), .a_valid(a_valid), .b_valid(b_valid),
   .ext_disarm(ext_disarm), .host_irq(host_irq),
   .clr(status_clr), .cap_pc(cap_pc_q)
);

// File: tb/addr_bkpt_detector_tb.sv
`timescale 1ns/1ps
module addr_bkpt_detector_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_we = 0;
   logic [2:0]  cfg_waddr = 0, cfg_raddr = 0;
   logic [31:0] cfg_wdata = 0, cfg_rdata;
   logic        ext_arm = 0, ext_disarm = 0;
   logic        a_valid = 0, b_valid = 0;
   logic [31:0] a_addr = 0, b_addr = 0, pc_in = 0;
   logic        evt_dbg_exc, evt_dbg_req, evt_trace_on, evt_trace_off, host_irq;

   int    checks = 0, errors = 0;
   string cur_req = "R1";
   bit    done = 0;

   always #2.5 clk = ~clk;

   addr_bkpt_detector u_dut (.*);

   // behavioural model
   logic [31:0] m_ref [2], m_mask [2];
   logic [5:0]  m_ctrl;
   bit          m_en;
   logic [4:0]  m_stat;
   logic [31:0] m_pc;
   logic [3:0]  m_evt;

   function automatic bit cmp_res(int k, bit v, logic [31:0] adr);
      bit eq = ((adr & m_mask[k]) == m_ref[k]);
      bit inv = (k == 0) ? m_ctrl[2] : m_ctrl[3];
      return v && (eq != inv);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ref = '{0, 0}; m_mask = '{0, 0};
         m_ctrl = 0; m_en = 0; m_stat = 0; m_pc = 0; m_evt = 0;
      end else begin
         bit ha, hb, comb, q, clr;
         ha = cmp_res(0, a_valid, a_addr);
         hb = cmp_res(1, b_valid, b_addr);
         case (m_ctrl[1:0])
            2'd0: comb = ha || hb;
            2'd1: comb = ha && hb;
            2'd2: comb = ha;
            default: comb = hb;
         endcase
         q = m_en && comb;
         clr = cfg_we && cfg_waddr == 6;
         m_evt = q ? (4'b1 << m_ctrl[5:4]) : 4'b0;
         if (q && (!m_stat[0] || clr)) begin
            m_stat = {m_ctrl[5:4], hb, ha, 1'b1};
            m_pc = pc_in;
         end else if (clr) begin
            m_stat = 0; m_pc = 0;
         end
         if (cfg_we) begin
            case (cfg_waddr)
               0: m_ref[0] = cfg_wdata;
               1: m_mask[0] = cfg_wdata;
               2: m_ref[1] = cfg_wdata;
               3: m_mask[1] = cfg_wdata;
               4: m_ctrl = cfg_wdata[5:0];
               default: ;
            endcase
         end
         if (ext_disarm) m_en = 0;
         else if (ext_arm) m_en = 1;
         else if (cfg_we && cfg_waddr == 5) m_en = cfg_wdata[0];
      end
   end

   function automatic logic [31:0] m_read(logic [2:0] i);
      case (i)
         0: return m_ref[0];
         1: return m_mask[0];
         2: return m_ref[1];
         3: return m_mask[1];
         4: return {26'b0, m_ctrl};
         5: return {31'b0, m_en};
         6: return {27'b0, m_stat};
         default: return m_pc;
      endcase
   endfunction

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("events", {28'b0, evt_trace_off, evt_trace_on, evt_dbg_req, evt_dbg_exc}, {28'b0, m_evt});
         chk("host_irq", {31'b0, host_irq}, {31'b0, m_stat[0]}); // R10
         chk("rdata", cfg_rdata, m_read(cfg_raddr));
      end
   end

   task automatic step();
      @(negedge clk); #1;
      cfg_we = 0; ext_arm = 0; ext_disarm = 0; a_valid = 0; b_valid = 0;
   endtask

   task automatic wr(logic [2:0] i, logic [31:0] d);
      cfg_we = 1; cfg_waddr = i; cfg_wdata = d;
      step();
   endtask

   task automatic acc(bit av, logic [31:0] aa, bit bv, logic [31:0] ba, logic [31:0] pc);
      a_valid = av; a_addr = aa; b_valid = bv; b_addr = ba; pc_in = pc;
      step();
   endtask

   task automatic sweep_reads();
      for (int i = 0; i < 8; i++) begin cfg_raddr = 3'(i); step(); end
   endtask

   task automatic expect_evt(int bitpos);
      step();
      checks++;
      if ({evt_trace_off, evt_trace_on, evt_dbg_req, evt_dbg_exc} !== 4'(1 << bitpos)) begin
         errors++;
         $display("FAIL %s direct event: actual %b expected %b", cur_req,
                  {evt_trace_off, evt_trace_on, evt_dbg_req, evt_dbg_exc}, 4'(1 << bitpos));
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      sweep_reads();
      cur_req = "R11";
      wr(0, 32'h1000_0040); wr(1, 32'hFFFF_FFF0);
      wr(2, 32'h2000_0000); wr(3, 32'hFFFF_0000);
      wr(4, 32'h0000_0000); wr(7, 32'hDEAD_BEEF);
      sweep_reads();
      cur_req = "R6";
      cfg_raddr = 6;
      acc(1, 32'h1000_0044, 1, 32'h2000_1234, 32'h400);
      acc(1, 32'h1000_0040, 0, 0, 32'h404);
      cur_req = "R7"; ext_arm = 1; step();
      cur_req = "R2";
      acc(0, 32'h1000_0044, 0, 32'h2000_0000, 32'h500);
      acc(1, 32'h1000_0050, 1, 32'h2100_0000, 32'h504);
      acc(1, 32'h1000_004F, 0, 0, 32'h508);
      cur_req = "R8";
      cfg_raddr = 7;
      acc(0, 0, 1, 32'h2000_ABCD, 32'h50C);
      acc(1, 32'h1000_0041, 1, 32'h2000_0001, 32'h510);
      cfg_raddr = 6; step();
      cur_req = "R9";
      wr(6, 0); cfg_raddr = 7; step();
      a_valid = 1; a_addr = 32'h1000_0042; pc_in = 32'h600; wr(6, 0);
      a_valid = 1; a_addr = 32'h1000_0043; pc_in = 32'h604; wr(6, 0);
      wr(6, 0);
      cur_req = "R5";
      for (int c = 0; c < 4; c++) begin
         wr(4, 32'(c << 4)); wr(6, 0);
         a_valid = 1; a_addr = 32'h1000_0040; pc_in = 32'h700 + 32'(c);
         expect_evt(c);
         step();
      end
      acc(1, 32'h1000_0040, 0, 0, 32'h720);
      acc(1, 32'h1000_0040, 0, 0, 32'h724);
      step();
      cur_req = "R3";
      wr(6, 0); wr(4, 32'h04); cfg_raddr = 6;
      acc(1, 32'h1000_0040, 0, 0, 32'h800);
      acc(0, 32'h3000_0000, 0, 0, 32'h804);
      acc(1, 32'h3000_0000, 0, 0, 32'h808);
      wr(6, 0); wr(4, 32'h0B);
      acc(0, 0, 1, 32'h2000_0000, 32'h810);
      acc(0, 0, 1, 32'h5000_0000, 32'h814);
      cur_req = "R4";
      for (int m = 0; m < 4; m++) begin
         wr(6, 0); wr(4, 32'(m));
         acc(1, 32'h1000_0040, 0, 0, 32'h900);
         acc(0, 0, 1, 32'h2000_7777, 32'h904);
         acc(1, 32'h1000_0048, 1, 32'h2000_0001, 32'h908);
         acc(1, 32'h1000_0048, 1, 32'h9000_0001, 32'h90C);
         wr(6, 0);
      end
      cur_req = "R7";
      cfg_raddr = 5;
      ext_arm = 1; ext_disarm = 1; step(); step();
      ext_arm = 1; cfg_we = 1; cfg_waddr = 5; cfg_wdata = 0; step(); step();
      wr(5, 0); step();
      acc(1, 32'h1000_0040, 1, 32'h2000_0000, 32'hA00);
      wr(5, 1);
      acc(1, 32'h1000_0040, 0, 0, 32'hA04);
      ext_disarm = 1; cfg_we = 1; cfg_waddr = 5; cfg_wdata = 1; step();
      acc(1, 32'h1000_0040, 0, 0, 32'hA08);
      sweep_reads();
      cur_req = "R1";
      rst_n = 0; step(); rst_n = 1;
      sweep_reads();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule